// File: doc/BRIEF.md
# Dual-Bank Edge Interrupt Controller

This block collects up to 64 peripheral event lines and turns them into a single interrupt request for a host CPU. The lines are split into two banks of up to 32. Each line is synchronized and watched for an edge. A polarity bit for each source picks whether the rising or the falling edge counts. A detected edge sets a sticky status bit that software clears by writing a one. An enable bit for each source decides whether its latched status drives the interrupt request. The request is registered, and it drops for one cycle on every clearing write, so a host that samples edges sees a new edge for the events still pending.

A second pair of registers in each bank, wake-enable and wake-polarity, works independently of the normal enable and polarity. It produces a one-cycle wake pulse for a power manager whenever a wake-enabled source shows an edge of its wake polarity. Software can retrigger a source by flipping its polarity bit twice while the line is steady. Each flip that turns the polarity-adjusted level from low to high counts as an edge.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and irq_o and wake_o are 0.
- R2: Source n below 32 maps to bit n of bank 0, and source n of 32 or above maps to bit n-32 of bank 1. A polarity bit of 0 latches the rising edge and a 1 latches the falling edge.
- R3: A status register reads back the latched events. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R4: irq_o is high exactly when some status bit has its enable bit set. Clearing an enable bit lowers irq_o but keeps the latched status.
- R5: A write to either status register with at least one implemented bit set forces irq_o low in the following cycle. irq_o returns high one cycle later if enabled status remains.
- R6: Inverting a source's polarity bit so that the polarity-adjusted level goes from 0 to 1 while the input is steady sets that source's status bit.
- R7: wake_o pulses for exactly one cycle for each edge, of the wake polarity (0 rising, 1 falling), on a source whose wake-enable bit is set. The normal enable and polarity bits have no effect on it.
- R8: Byte offsets within the 64-byte space: enable 0x00 and 0x04, polarity 0x08 and 0x0C, status 0x10 and 0x14, wake-enable 0x18 and 0x1C, wake-polarity 0x20 and 0x24, with bank 0 at the lower offset of each pair. Bits above the implemented source count read 0. Other or misaligned addresses read 0 and ignore writes.
- R9: When a new edge and a clearing write hit the same status bit on the same clock edge, the bit stays set.
- R10: A change on a source input reaches status and irq_o on the third rising clock edge after the change (two synchronizer stages plus one detect stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| src_i | input | NUM_SRC | Raw event lines, asynchronous |
| irq_o | output | 1 | Interrupt request toward the host |
| wake_o | output | 1 | One-cycle wake request pulse |

## Verification
The assertions assume that src_i is clean once synchronized. They also assume that a status bit changes only through a detected edge or a clearing write, so they treat any drop without a status write as a fault. The bench changes sources and register contents only on falling clock edges, and it holds each source level for several cycles. As a result every edge passes through the synchronizer as one clean transition. The same-edge collision of a new edge and a clear is produced on purpose by counting the three register stages from the source change.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned REG_AW    = 6;

  typedef enum logic [2:0] {
    KIND_EN   = 3'd0,
    KIND_POL  = 3'd1,
    KIND_STAT = 3'd2,
    KIND_WEN  = 3'd3,
    KIND_WPOL = 3'd4
  } reg_kind_e;

  function automatic int unsigned bank_bits(int unsigned n, int unsigned b);
    if (n <= b * BANK_W) return 0;
    if (n - b * BANK_W >= BANK_W) return BANK_W;
    return n - b * BANK_W;
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2  // at least 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/eic_bank.sv
module eic_bank
  import eic_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  reg_kind_e    kind_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rdata_o,
  output logic         pend_o,
  output logic         clr_o,
  output logic         wake_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] wen_o
);
  logic [W-1:0] en_q, pol_q, st_q, wen_q, wpol_q, eff_q, weff_q;
  logic [W-1:0] eff, weff, evt, wevt, en_d, st_d, clr_mask;
  logic wr_en, wr_pol, wr_st, wr_wen, wr_wpol;

  assign wr_en   = wr_i && (kind_i == KIND_EN);
  assign wr_pol  = wr_i && (kind_i == KIND_POL);
  assign wr_st   = wr_i && (kind_i == KIND_STAT);
  assign wr_wen  = wr_i && (kind_i == KIND_WEN);
  assign wr_wpol = wr_i && (kind_i == KIND_WPOL);

  // polarity-adjusted levels: a flip of pol while steady is an edge too
  assign eff  = lvl_i ^ pol_q;
  assign evt  = eff & ~eff_q;
  assign weff = lvl_i ^ wpol_q;
  assign wevt = weff & ~weff_q & wen_q;

  assign clr_mask = wr_st ? wdata_i : '0;
  assign st_d     = (st_q & ~clr_mask) | evt;  // new edge beats clear
  assign en_d     = wr_en ? wdata_i : en_q;

  assign pend_o = |(st_d & en_d);
  assign clr_o  = wr_st && (|wdata_i);
  assign wake_o = |wevt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      st_q   <= '0;
      wen_q  <= '0;
      wpol_q <= '0;
      eff_q  <= '0;
      weff_q <= '0;
    end else begin
      en_q   <= en_d;
      st_q   <= st_d;
      eff_q  <= eff;
      weff_q <= weff;
      if (wr_pol)  pol_q  <= wdata_i;
      if (wr_wen)  wen_q  <= wdata_i;
      if (wr_wpol) wpol_q <= wdata_i;
    end
  end

  always_comb begin
    case (kind_i)
      KIND_EN:   rdata_o = en_q;
      KIND_POL:  rdata_o = pol_q;
      KIND_STAT: rdata_o = st_q;
      KIND_WEN:  rdata_o = wen_q;
      KIND_WPOL: rdata_o = wpol_q;
      default:   rdata_o = '0;
    endcase
  end

  assign stat_o = st_q;
  assign en_o   = en_q;
  assign wen_o  = wen_q;
endmodule

// File: rtl/eic_req_out.sv
module eic_req_out #(
  parameter int unsigned NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] pend_i,
  input  logic [NB-1:0] clr_i,
  input  logic [NB-1:0] wake_i,
  output logic          irq_o,
  output logic          wake_o
);
  logic irq_q, wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      // any clearing write forces a one-cycle gap for edge-sampling hosts
      irq_q  <= (|pend_i) && !(|clr_i);
      wake_q <= |wake_i;
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 55,  // 33..64
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [BANK_W-1:0]  wdata_i,
  input  logic               we_i,
  output logic [BANK_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               wake_o
);
  localparam int unsigned NB  = NUM_BANKS;
  localparam int unsigned ALL = NB * BANK_W;

  logic [3:0]         idx;
  reg_kind_e          kind;
  logic               bsel, acc_ok;
  logic [NUM_SRC-1:0] lvl;

  logic [NB-1:0][BANK_W-1:0] bank_rd;
  logic [NB-1:0]             pend, clr, wake;
  logic [ALL-1:0]            st_all, en_all, wen_all;

  assign idx    = addr_i[5:2];
  assign kind   = reg_kind_e'(idx[3:1]);
  assign bsel   = idx[0];
  assign acc_ok = (idx[3:1] <= 3'd4) && (addr_i[1:0] == 2'b00);

  eic_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (lvl)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int unsigned W   = bank_bits(NUM_SRC, b);
    localparam int unsigned LSB = b * BANK_W;
    logic [W-1:0] rd_w, st_w, en_w, wen_w;

    eic_bank #(.W(W)) i_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i && acc_ok && (bsel == b[0])),
      .kind_i (kind),
      .wdata_i(wdata_i[W-1:0]),
      .lvl_i  (lvl[LSB +: W]),
      .rdata_o(rd_w),
      .pend_o (pend[b]),
      .clr_o  (clr[b]),
      .wake_o (wake[b]),
      .stat_o (st_w),
      .en_o   (en_w),
      .wen_o  (wen_w)
    );

    assign bank_rd[b]             = BANK_W'(rd_w);
    assign st_all[LSB +: BANK_W]  = BANK_W'(st_w);
    assign en_all[LSB +: BANK_W]  = BANK_W'(en_w);
    assign wen_all[LSB +: BANK_W] = BANK_W'(wen_w);
  end

  assign rdata_o = acc_ok ? bank_rd[bsel] : '0;

  eic_req_out #(.NB(NB)) i_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pend_i(pend),
    .clr_i (clr),
    .wake_i(wake),
    .irq_o (irq_o),
    .wake_o(wake_o)
  );
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int unsigned NUM_SRC = 55
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [5:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        irq_o,
  input logic        wake_o,
  input logic [63:0] st_all,
  input logic [63:0] en_all,
  input logic [63:0] wen_all
);
  localparam int unsigned HI_BITS = NUM_SRC - 32;
  localparam logic [63:0] HI_FULL = (64'd1 << HI_BITS) - 64'd1;
  localparam logic [31:0] HI_MASK = HI_FULL[31:0];

  logic wr_st0, wr_st1, clr_any;
  assign wr_st0  = we_i && (addr_i == 6'h10);
  assign wr_st1  = we_i && (addr_i == 6'h14);
  assign clr_any = (wr_st0 && (|wdata_i)) || (wr_st1 && (|(wdata_i & HI_MASK)));

  // R5
  a_r5_clear_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_any |=> !irq_o);

  // R4
  a_r4_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(st_all & en_all)));

  // R3
  a_r3_sticky_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_st0 |=> (($past(st_all[31:0]) & ~st_all[31:0]) == 32'd0));

  a_r3_sticky_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_st1 |=> (($past(st_all[63:32]) & ~st_all[63:32]) == 32'd0));

  // R7
  a_r7_wake_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(|wen_all));
endmodule

bind edge_irq_ctrl eic_checker #(.NUM_SRC(NUM_SRC)) i_eic_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .wake_o (wake_o),
  .st_all (st_all),
  .en_all (en_all),
  .wen_all(wen_all)
);

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
  localparam int unsigned NUM_SRC = 55;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [5:0]         addr = '0;
  logic [31:0]        wdata = '0;
  logic               we = 1'b0;
  logic [31:0]        rdata;
  logic [NUM_SRC-1:0] src = '0;
  logic               irq, wake;

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_irq_ctrl #(.NUM_SRC(NUM_SRC)) i_edge_irq_ctrl (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .addr_i (addr),
    .wdata_i(wdata),
    .we_i   (we),
    .rdata_o(rdata),
    .src_i  (src),
    .irq_o  (irq),
    .wake_o (wake)
  );

  always @(negedge clk) if (rst_ni && wake) wake_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_src(input int i, input logic v, input int wait_n);
    @(negedge clk);
    src[i] = v;
    cyc(wait_n);
  endtask

  task automatic quiesce();
    for (int a = 0; a < 10; a++) if (a != 4 && a != 5) wr(6'(a * 4), 32'd0);
    cyc(4);
    wr(6'h10, '1);
    wr(6'h14, '1);
    cyc(1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 10; a++) begin
      rd(6'(a * 4), d);
      chk("R1 reg after reset", d, 32'd0);
    end
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 wake after reset", {31'd0, wake}, 32'd0);
  endtask

  task automatic t_latency_rise();
    logic [31:0] d;
    quiesce();
    wr(6'h00, 32'h8);
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); chk("R10 irq one edge after", {31'd0, irq}, 32'd0);
    @(negedge clk); chk("R10 irq two edges after", {31'd0, irq}, 32'd0);
    @(negedge clk); chk("R10 irq three edges after", {31'd0, irq}, 32'd1);
    rd(6'h10, d); chk("R2 rising edge latched", d, 32'h8);
    set_src(5, 1'b1, 5);
    rd(6'h10, d); chk("R2 second source latched", d, 32'h28);
    chk("R4 irq held", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(6'h10, 32'd0);
    rd(6'h10, d); chk("R3 write zero keeps", d, 32'h28);
    wr(6'h10, 32'h20);
    rd(6'h10, d); chk("R3 write one clears bit", d, 32'h8);
    wr(6'h10, 32'h8);
    cyc(2);
    rd(6'h10, d); chk("R3 all cleared", d, 32'h0);
    chk("R4 irq low when no status", {31'd0, irq}, 32'd0);
    set_src(3, 1'b0, 0);
    set_src(5, 1'b0, 5);
    rd(6'h10, d); chk("R2 falling ignored at pol 0", d, 32'h0);
  endtask

  task automatic t_high_bank();
    logic [31:0] d;
    quiesce();
    wr(6'h0C, 32'h100);
    cyc(3);
    wr(6'h14, '1);
    set_src(40, 1'b1, 5);
    rd(6'h14, d); chk("R2 rise ignored at pol 1", d, 32'h0);
    set_src(40, 1'b0, 5);
    rd(6'h14, d); chk("R2 src40 falling to bank1 bit8", d, 32'h100);
    set_src(32, 1'b1, 5);
    rd(6'h14, d); chk("R2 src32 to bank1 bit0", d, 32'h101);
    set_src(32, 1'b0, 2);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    quiesce();
    set_src(20, 1'b1, 5);
    chk("R4 disabled source no irq", {31'd0, irq}, 32'd0);
    wr(6'h00, 32'h0010_0000);
    chk("R4 enabling latched source", {31'd0, irq}, 32'd1);
    wr(6'h00, 32'd0);
    chk("R4 masking drops irq", {31'd0, irq}, 32'd0);
    rd(6'h10, d); chk("R4 status kept when masked", d, 32'h0010_0000);
    set_src(20, 1'b0, 2);
  endtask

  task automatic t_glitch();
    quiesce();
    wr(6'h00, 32'h6);
    @(negedge clk); src[1] = 1'b1; src[2] = 1'b1;
    cyc(5);
    chk("R5 irq before clear", {31'd0, irq}, 32'd1);
    wr(6'h10, 32'h2);
    chk("R5 irq drops after clear", {31'd0, irq}, 32'd0);
    cyc(1);
    chk("R5 irq returns with pending", {31'd0, irq}, 32'd1);
    wr(6'h10, 32'h4);
    chk("R5 irq low after last clear", {31'd0, irq}, 32'd0);
    cyc(1);
    chk("R5 irq stays low", {31'd0, irq}, 32'd0);
    @(negedge clk); src[1] = 1'b0; src[2] = 1'b0;
    cyc(4);
  endtask

  task automatic t_retrigger();
    logic [31:0] d;
    quiesce();
    set_src(9, 1'b1, 5);
    wr(6'h10, '1);
    cyc(2);
    rd(6'h10, d); chk("R6 cleared before retrigger", d, 32'h0);
    wr(6'h08, 32'h200);
    cyc(3);
    rd(6'h10, d); chk("R6 first flip no event", d, 32'h0);
    wr(6'h08, 32'h0);
    cyc(3);
    rd(6'h10, d); chk("R6 second flip sets status", d, 32'h200);
    set_src(9, 1'b0, 3);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    quiesce();
    set_src(7, 1'b1, 5);
    set_src(7, 1'b0, 5);
    rd(6'h10, d); chk("R9 setup latched", d, 32'h80);
    @(negedge clk); src[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 6'h10; wdata = 32'h80; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(6'h10, d); chk("R9 edge beats clear", d, 32'h80);
    wr(6'h10, 32'h80);
    rd(6'h10, d); chk("R3 plain clear", d, 32'h0);
    set_src(7, 1'b0, 3);
  endtask

  task automatic t_wake();
    int c0;
    quiesce();
    c0 = wake_cnt;
    wr(6'h18, 32'h1000);
    set_src(12, 1'b1, 5);
    chk("R7 wake on rise", 32'(wake_cnt - c0), 32'd1);
    chk("R7 irq untouched by wake", {31'd0, irq}, 32'd0);
    wr(6'h20, 32'h1000);
    cyc(4);
    chk("R7 wake polarity flip to low no pulse", 32'(wake_cnt - c0), 32'd1);
    set_src(12, 1'b0, 5);
    chk("R7 wake on fall at wpol 1", 32'(wake_cnt - c0), 32'd2);
    set_src(12, 1'b1, 5);
    chk("R7 no wake on rise at wpol 1", 32'(wake_cnt - c0), 32'd2);
    set_src(13, 1'b1, 5);
    chk("R7 no wake without wake enable", 32'(wake_cnt - c0), 32'd2);
    wr(6'h18, 32'd0);
    @(negedge clk); src[12] = 1'b0; src[13] = 1'b0;
    cyc(4);
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    quiesce();
    wr(6'h04, '1);
    rd(6'h04, d); chk("R8 upper bank1 bits read 0", d, 32'h007F_FFFF);
    wr(6'h00, 32'h55);
    wr(6'h28, '1);
    rd(6'h28, d); chk("R8 unmapped reads 0", d, 32'h0);
    rd(6'h00, d); chk("R8 unmapped write ignored", d, 32'h55);
    wr(6'h01, '1);
    rd(6'h01, d); chk("R8 misaligned reads 0", d, 32'h0);
    rd(6'h00, d); chk("R8 misaligned write ignored", d, 32'h55);
    quiesce();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_latency_rise();
    t_w1c();
    t_high_bank();
    t_mask();
    t_glitch();
    t_retrigger();
    t_collide();
    t_wake();
    t_unimpl();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule